// File: doc/BRIEF.md
# Local Bus Width-Halving Transfer Sequencer

This block sits on the master side of a 32-bit local bus that must also reach targets only 16 bits wide. For each 32-bit transfer it takes a start strobe and four active-low byte enables. It drives those enables onto the bus and watches two target inputs: a ready signal and a narrow-target flag. The ready signal ends an access. The narrow-target flag reports that the target is only 16 bits wide.

The narrow-target flag counts only when the block saw it at a clock edge strictly earlier than the edge that samples ready. When the flag counts, the block checks whether the transfer has active bytes in both the lower and the upper halves of the word. If it does, the block runs a second access after the first ready. The second access carries only the upper-half enables. Transfers confined to one half finish in one access. So do transfers whose narrow flag came too late.

When the last required access is acknowledged, the block pulses a done strobe. Data steering, address generation, arbitration and target-mode behaviour belong to other blocks.

Top module: `bus_halver`

## Requirements
- R1: After a synchronous active-low reset, the byte-enable output is all ones (no byte enabled), busy is low and done is low.
- R2: A start sampled while idle captures the byte enables. From the next cycle the block drives them unchanged on the bus with busy high.
- R3: The narrow-target flag qualifies a transfer only if it was sampled high at an edge of the first access strictly before the edge at which ready is sampled high. A flag that is high only on the ready edge does not qualify.
- R4: Enable bit i low means byte i is active. Bits 1:0 form the lower half and bits 3:2 the upper half. A second access is needed only when the flag qualified and both halves contain an active byte (e.g. 1000, 0000, 1001, 0001).
- R5: The second access starts in the cycle after the first ready. It drives bits 3:2 at their captured values and bits 1:0 as 11 (1000 becomes 1011, 0000 becomes 0011).
- R6: Transfers with one half fully inactive (e.g. 1110, 1100, 1101, 0011, 0111, 1011), and transfers without a qualified flag, end on the first ready.
- R7: Done is a one-cycle pulse in the cycle after the ready that ends the last required access. In that cycle busy is low and the enables are all ones.
- R8: A start arriving while a transfer is in progress is ignored. The captured enables and the access sequence stay unchanged.
- R9: Reset asserted in the middle of a transfer returns the block to idle with no done pulse. Ready sampled while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start of a 32-bit transfer |
| be_n_i | input | 4 | Requested byte enables, active low |
| rdy_i | input | 1 | Target ready, active high, ends an access |
| narrow_i | input | 1 | Target reports 16-bit width, active high |
| bus_be_n_o | output | 4 | Byte enables for the current access, active low |
| busy_o | output | 1 | An access is in progress |
| done_o | output | 1 | One-cycle pulse when the transfer has finished |

## Verification
Two decisions can land on the same clock edge: qualifying the narrow-target flag and ending the first access on ready. The bench drives both inputs high for that single edge. It then requires a single access with done in the next cycle and no second access, while the same enables with the flag raised one cycle earlier must split. A second collision is a new start presented in the same cycle as the done pulse. That start must be accepted, with its enables on the bus in the following cycle.

// File: rtl/bus_halver_pkg.sv
// Package: shared state encoding for the width-halving transfer sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package bus_halver_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/bus_halver_decode.sv
// Module: bus_halver_decode
// Decides from the captured byte enables whether a narrow target needs a
// second access and forms the enables for that access.
// Assumes BE_W is even; the lower half holds the low-numbered bytes.
module bus_halver_decode #(
    parameter int BE_W = 4
) (
    input  logic [BE_W-1:0] cap_be_n_i,
    output logic            split_o,
    output logic [BE_W-1:0] second_be_n_o
);
    localparam int HALF = BE_W / 2;

    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;

    // Split the captured enables into halves.
    always_comb begin
        lo_half = cap_be_n_i[HALF-1:0];
        hi_half = cap_be_n_i[BE_W-1:HALF];
    end

    // Both halves need an active (low) byte for a second access.
    always_comb begin
        split_o       = (~&lo_half) && (~&hi_half);
        second_be_n_o = {hi_half, {HALF{1'b1}}};
    end
endmodule

// File: rtl/bus_halver_qual.sv
// Module: bus_halver_qual
// Remembers whether the narrow-target flag was seen at an edge of the
// current first access. The flag seen on a given edge becomes visible only
// afterwards, so a flag coinciding with ready never qualifies.
// Assumes clr_i is high whenever the first access is not running.
module bus_halver_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic narrow_i,
    output logic qual_o
);
    logic seen_q;

    // Sticky flag, cleared outside the first access and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            seen_q <= 1'b0;
        end else if (narrow_i) begin
            seen_q <= 1'b1;
        end
    end

    assign qual_o = seen_q;

    // R3: the flag cannot be qualified in the cycle right after a clear
    a_r3_not_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !qual_o);
endmodule

// File: rtl/bus_halver_fsm.sv
// Module: bus_halver_fsm
// Sequences one or two accesses per transfer, drives the bus enables and
// produces busy and the done pulse.
// Assumes ready is only meaningful while an access is in progress.
module bus_halver_fsm
    import bus_halver_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [BE_W-1:0] be_n_i,
    input  logic            rdy_i,
    input  logic            qual_i,
    input  logic            split_i,
    input  logic [BE_W-1:0] second_be_n_i,
    output logic            clr_qual_o,
    output logic [BE_W-1:0] cap_be_n_o,
    output logic [BE_W-1:0] bus_be_n_o,
    output logic            busy_o,
    output logic            done_o
);
    localparam int HALF = BE_W / 2;
    localparam logic [BE_W-1:0] NONE = {BE_W{1'b1}};

    xfer_state_t     state_q;
    xfer_state_t     state_d;
    logic [BE_W-1:0] cap_q;
    logic            done_q;
    logic            done_d;

    // Next state and done decision.
    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (rdy_i) begin
                    if (qual_i && split_i) begin
                        state_d = ST_SECOND;
                    end else begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                end
            end
            ST_SECOND: begin
                if (rdy_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, done pulse and enable capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            cap_q   <= NONE;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            if (state_q == ST_IDLE && start_i) cap_q <= be_n_i;
        end
    end

    // Drive the bus enables for the access in progress.
    always_comb begin
        case (state_q)
            ST_FIRST:  bus_be_n_o = cap_q;
            ST_SECOND: bus_be_n_o = second_be_n_i;
            default:   bus_be_n_o = NONE;
        endcase
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign cap_be_n_o = cap_q;
    assign clr_qual_o = (state_q != ST_FIRST);

    // R8: captured enables never change once a transfer is running
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (cap_q == $past(cap_q)));

    // R4: a second access only runs with active bytes in both halves
    a_r4_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |-> ((~&cap_q[HALF-1:0]) && (~&cap_q[BE_W-1:HALF])));

    // R3: ready without a qualified flag ends the transfer
    a_r3_late_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && rdy_i && !qual_i) |=> (state_q == ST_IDLE));

    // R5: upper enables carry over unchanged into the second access
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRST && state_d == ST_SECOND) |=>
        (bus_be_n_o[BE_W-1:HALF] == $past(bus_be_n_o[BE_W-1:HALF])));

    // R7: done follows a ready seen during an access, lasts one cycle
    a_r7_done_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_o && bus_be_n_o == NONE));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/bus_halver.sv
// Module: bus_halver (top)
// Master-side sequencer that turns a 32-bit transfer into one or two
// accesses depending on target width and the active byte enables.
// Assumes inputs are synchronous to clk; target mode is handled elsewhere.
module bus_halver #(
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [BE_W-1:0] be_n_i,
    input  logic            rdy_i,
    input  logic            narrow_i,
    output logic [BE_W-1:0] bus_be_n_o,
    output logic            busy_o,
    output logic            done_o
);
    logic            qual;
    logic            clr_qual;
    logic            split;
    logic [BE_W-1:0] cap_be_n;
    logic [BE_W-1:0] second_be_n;

    bus_halver_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_qual),
        .narrow_i (narrow_i),
        .qual_o   (qual)
    );

    bus_halver_decode #(.BE_W(BE_W)) u_decode (
        .cap_be_n_i    (cap_be_n),
        .split_o       (split),
        .second_be_n_o (second_be_n)
    );

    bus_halver_fsm #(.BE_W(BE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .be_n_i        (be_n_i),
        .rdy_i         (rdy_i),
        .qual_i        (qual),
        .split_i       (split),
        .second_be_n_i (second_be_n),
        .clr_qual_o    (clr_qual),
        .cap_be_n_o    (cap_be_n),
        .bus_be_n_o    (bus_be_n_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    // R9: an idle block never raises done on the next cycle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o && !done_o);
endmodule

// File: tb/sim_bus_halver.sv
module sim_bus_halver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] be_n_i = 4'hF;
    logic       rdy_i = 1'b0;
    logic       narrow_i = 1'b0;
    logic [3:0] bus_be_n_o;
    logic       busy_o;
    logic       done_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    bus_halver u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .be_n_i(be_n_i),
        .rdy_i(rdy_i), .narrow_i(narrow_i), .bus_be_n_o(bus_be_n_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic needs_two(input logic [3:0] be);
        return (be[1:0] != 2'b11) && (be[3:2] != 2'b11);
    endfunction

    // Generic transfer; lead=1 raises the flag one edge before ready,
    // lead=2 raises it only on the ready edge, lead=0 never.
    task automatic xfer(input logic [3:0] be, input int lead, input string req);
        logic two;
        two = (lead == 1) && needs_two(be);
        start_i = 1'b1; be_n_i = be;
        step();
        start_i = 1'b0; be_n_i = 4'hF;
        chk({req, " R2 first enables"}, bus_be_n_o, be);
        chk({req, " R2 busy"}, busy_o, 1'b1);
        if (lead == 1) begin
            narrow_i = 1'b1;
            step();
        end
        rdy_i = 1'b1;
        if (lead == 2) narrow_i = 1'b1;
        step();
        rdy_i = 1'b0; narrow_i = 1'b0;
        if (two) begin
            chk({req, " R5 second enables"}, bus_be_n_o, {be[3:2], 2'b11});
            chk({req, " R5 busy"}, busy_o, 1'b1);
            chk({req, " R7 no early done"}, done_o, 1'b0);
            step();
            chk({req, " R5 second held"}, bus_be_n_o, {be[3:2], 2'b11});
            rdy_i = 1'b1;
            step();
            rdy_i = 1'b0;
        end
        chk({req, " R7 done"}, done_o, 1'b1);
        chk({req, " R7 idle busy"}, busy_o, 1'b0);
        chk({req, " R7 idle enables"}, bus_be_n_o, 4'hF);
        step();
        chk({req, " R7 done one cycle"}, done_o, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 enables", bus_be_n_o, 4'hF);
        chk("R1 busy", busy_o, 1'b0);
        chk("R1 done", done_o, 1'b0);
    endtask

    task automatic t_split_examples();
        xfer(4'b1000, 1, "R4 1000");
        xfer(4'b0000, 1, "R4 0000");
        xfer(4'b1001, 1, "R4 1001");
        xfer(4'b0001, 1, "R4 0001");
    endtask

    task automatic t_single_half();
        xfer(4'b1110, 1, "R6 1110");
        xfer(4'b1100, 1, "R6 1100");
        xfer(4'b1101, 1, "R6 1101");
        xfer(4'b0011, 1, "R6 0011");
        xfer(4'b0111, 1, "R6 0111");
        xfer(4'b1011, 1, "R6 1011");
    endtask

    task automatic t_all_patterns();
        for (int i = 0; i < 16; i++) xfer(4'(i), 1, "R4 sweep");
    endtask

    task automatic t_no_flag();
        xfer(4'b0000, 0, "R6 no flag");
    endtask

    task automatic t_flag_on_ready();
        xfer(4'b0000, 2, "R3 flag with ready");
    endtask

    task automatic t_start_busy();
        start_i = 1'b1; be_n_i = 4'b1110;
        step();
        be_n_i = 4'b0000;
        narrow_i = 1'b1;
        step();
        start_i = 1'b0; narrow_i = 1'b0; be_n_i = 4'hF;
        chk("R8 enables kept", bus_be_n_o, 4'b1110);
        rdy_i = 1'b1;
        step();
        rdy_i = 1'b0;
        chk("R8 single access done", done_o, 1'b1);
        chk("R8 no second access", busy_o, 1'b0);
        step();
    endtask

    task automatic t_reset_mid();
        start_i = 1'b1; be_n_i = 4'b0000;
        step();
        start_i = 1'b0;
        narrow_i = 1'b1;
        step();
        narrow_i = 1'b0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R9 reset busy", busy_o, 1'b0);
        chk("R9 reset enables", bus_be_n_o, 4'hF);
        rdy_i = 1'b1;
        step();
        chk("R9 idle ready no done", done_o, 1'b0);
        step();
        rdy_i = 1'b0;
        chk("R9 idle ready still idle", busy_o, 1'b0);
    endtask

    task automatic t_start_on_done();
        start_i = 1'b1; be_n_i = 4'b0011;
        step();
        start_i = 1'b0;
        rdy_i = 1'b1;
        step();
        rdy_i = 1'b0;
        chk("R7 done before restart", done_o, 1'b1);
        start_i = 1'b1; be_n_i = 4'b1100;
        step();
        start_i = 1'b0;
        chk("R2 start during done accepted", bus_be_n_o, 4'b1100);
        chk("R2 busy after restart", busy_o, 1'b1);
        rdy_i = 1'b1;
        step();
        rdy_i = 1'b0;
        chk("R7 restart done", done_o, 1'b1);
        step();
    endtask

    initial begin
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        t_reset();
        t_split_examples();
        t_single_half();
        t_all_patterns();
        t_no_flag();
        t_flag_on_ready();
        t_start_busy();
        t_reset_mid();
        t_start_on_done();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule